// File: doc/BRIEF.md
# Programmable Clock Output Channels

This block drives three independent clock outputs. Each output comes from one of three source clocks (slow, main, PLL) and is divided by a power of two from 1 to 64. The source clocks arrive as level signals that are synchronous to the system clock `clk`. The block finds their rising edges and counts them, so the whole design runs in a single clock domain.

Software reaches the block through a simple register port. The port has one write strobe, a word address and write data, plus a combinational read-data bus. A channel is switched on through a write-one-to-set register and switched off through a write-one-to-clear register. A read-only register shows which channels are on. A second read-only register holds one ready flag per channel. The flag rises with the first high edge of the divided output after the channel is switched on.

Each ready flag can drive the shared interrupt line once its mask bit is set. Mask bits are set and cleared through their own pair of write-one registers. A channel's source and divider can only be changed while that channel is off. The intended sequence is: switch the channel off, reconfigure it, switch it back on, then wait for ready.

Top module: `progclk_gen`

## Requirements
- R1: After reset, all channels are off, every output is low, every ready flag and mask bit is 0, and every configuration register reads 0 (slow source, divide by 1).
- R2: Word address 0 sets channel enables and address 1 clears them, one bit per channel with a 1 meaning act. Address 2 reads the enable state, with bit i for channel i.
- R3: Channel i's configuration register is at address 8+i. Bits [1:0] select the source and bits [4:2] hold the prescaler code. All other bits read 0, so writing 0x15 gives main clock divided by 32.
- R4: Source code 0 selects the slow clock, 1 the main clock, 2 the PLL clock and 3 the slow clock. Edges on any unselected source have no effect on the output.
- R5: For prescaler code c from 1 to 7, the divide ratio is N = 2^min(c,6). The output toggles once per N/2 rising edges of the selected source. After enable, it first goes high on the N/2-th rising edge.
- R6: With code 0 (divide by 1), the output follows the selected source level one `clk` cycle later.
- R7: A channel's ready flag (address 3, bit i) is set at the same clock edge where its output first goes high after enable. It then stays set while the channel stays on.
- R8: A configuration write to a channel that is on is ignored, and the register keeps its previous value.
- R9: At the edge that registers a disable write, the channel's output goes low and its ready flag clears. This holds even if a source edge arrives in that same cycle.
- R10: Address 4 sets mask bits, address 5 clears them and address 6 reads them. `irq` is high exactly when some channel has both its ready flag and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_slow | input | 1 | Slow source clock level, synchronous to clk |
| src_main | input | 1 | Main source clock level, synchronous to clk |
| src_pll | input | 1 | PLL source clock level, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr (combinational) |
| pclk_o | output | 3 | Divided clock outputs, one per channel |
| irq | output | 1 | Masked ready interrupt |

## Verification
A disable write can land in the same cycle as a rising edge of the channel's selected source. That edge alone would raise the output and the ready flag. The bench provokes this on a divide-by-1 channel by raising the slow source in the very cycle it issues the disable write. It then expects the output low, the ready flag clear and the enable bit clear. A control run re-enables the channel with the source still high and expects ready to rise, which shows the edge would otherwise have counted.

// File: rtl/progclk_pkg.sv
package progclk_pkg;

    localparam int PRES_MAX = 6;
    localparam int DIV_W    = PRES_MAX + 1;
    localparam int CNT_W    = PRES_MAX;
    localparam int N_SRC    = 3;
    localparam int CFG_W    = 5;

    localparam int A_EN_SET  = 0;
    localparam int A_EN_CLR  = 1;
    localparam int A_EN_STAT = 2;
    localparam int A_RDY     = 3;
    localparam int A_IM_SET  = 4;
    localparam int A_IM_CLR  = 5;
    localparam int A_IM_STAT = 6;
    localparam int A_CFG0    = 8;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_ALT  = 2'd3
    } src_e;

    typedef struct packed {
        logic [2:0] pres;
        src_e       src;
    } cfg_t;

endpackage

// File: rtl/progclk_regs.sv
module progclk_regs
    import progclk_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_CH-1:0]   rdy,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_CH-1:0]   en_q_o,
    output logic [NUM_CH-1:0]   en_d_o,
    output cfg_t [NUM_CH-1:0]   cfg_o,
    output logic                irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] mask;
        cfg_t [NUM_CH-1:0] cfg;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_bits;

    assign unused_bits = ^wdata[DATA_W-1:CFG_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (int'(addr))
                A_EN_SET: st_d.en   = st_q.en | wdata[NUM_CH-1:0];
                A_EN_CLR: st_d.en   = st_q.en & ~wdata[NUM_CH-1:0];
                A_IM_SET: st_d.mask = st_q.mask | wdata[NUM_CH-1:0];
                A_IM_CLR: st_d.mask = st_q.mask & ~wdata[NUM_CH-1:0];
                default: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        if (int'(addr) == A_CFG0 + i && !st_q.en[i]) begin
                            st_d.cfg[i] = cfg_t'(wdata[CFG_W-1:0]);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_EN_STAT: rdata = DATA_W'(st_q.en);
            A_RDY:     rdata = DATA_W'(rdy);
            A_IM_STAT: rdata = DATA_W'(st_q.mask);
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (int'(addr) == A_CFG0 + i) rdata = DATA_W'(st_q.cfg[i]);
                end
            end
        endcase
    end

    assign en_q_o = st_q.en;
    assign en_d_o = st_d.en;
    assign cfg_o  = st_q.cfg;
    assign irq    = |(rdy & st_q.mask);

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_EN_SET) |=>
            ((st_q.en & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0]))); // R2

    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_IM_CLR) |=>
            ((st_q.mask & $past(wdata[NUM_CH-1:0])) == '0)); // R10

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg_chk
        AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.en[g] |=> $stable(st_q.cfg[g])); // R8
    end

endmodule

// File: rtl/progclk_chan.sv
module progclk_chan
    import progclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             en_next,
    input  cfg_t             cfg,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic [N_SRC-1:0] src_rise,
    output logic             clk_o,
    output logic             ready
);

    typedef struct packed {
        logic             out;
        logic             rdy;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t            st_d, st_q;
    int               sel;
    logic             lvl, rise;
    logic [2:0]       eff;
    logic [DIV_W-1:0] div_v;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        case (cfg.src)
            SRC_MAIN: sel = 1;
            SRC_PLL:  sel = 2;
            default:  sel = 0;
        endcase
        lvl     = src_lvl[sel];
        rise    = src_rise[sel];
        eff     = (cfg.pres > 3'(PRES_MAX)) ? 3'(PRES_MAX) : cfg.pres;
        div_v   = DIV_W'(1) << eff;
        half_m1 = CNT_W'(div_v >> 1) - CNT_W'(1);

        st_d = st_q;
        if (!en_next) begin
            st_d = '0;
        end else if (en) begin
            if (eff == 3'd0) begin
                st_d.out = lvl;
            end else if (rise) begin
                if (st_q.cnt == half_m1) begin
                    st_d.cnt = '0;
                    st_d.out = ~st_q.out;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            if (st_d.out && !st_q.out) st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_o = st_q.out;
    assign ready = st_q.rdy;

    AST_OFF_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !st_q.out); // R9

    AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !st_q.rdy); // R9

    AST_READY_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy) |-> st_q.out); // R7

    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_next && st_q.rdy) |=> st_q.rdy); // R7

endmodule

// File: rtl/progclk_gen.sv
module progclk_gen
    import progclk_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_slow,
    input  logic              src_main,
    input  logic              src_pll,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pclk_o,
    output logic              irq
);

    logic [N_SRC-1:0]  src_lvl, prev_d, prev_q, src_rise;
    logic [NUM_CH-1:0] en_q, en_d, rdy;
    cfg_t [NUM_CH-1:0] cfg;

    always_comb begin
        src_lvl  = {src_pll, src_main, src_slow};
        prev_d   = src_lvl;
        src_rise = src_lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    progclk_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdy    (rdy),
        .rdata  (rdata),
        .en_q_o (en_q),
        .en_d_o (en_d),
        .cfg_o  (cfg),
        .irq    (irq)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        progclk_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q[g]),
            .en_next  (en_d[g]),
            .cfg      (cfg[g]),
            .src_lvl  (src_lvl),
            .src_rise (src_rise),
            .clk_o    (pclk_o[g]),
            .ready    (rdy[g])
        );
    end

    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdy != '0)); // R10

endmodule

// File: tb/sim_progclk_gen.sv
module sim_progclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  srcs = 3'b000;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [2:0]  pclk_o;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    progclk_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_slow (srcs[0]),
        .src_main (srcs[1]),
        .src_pll  (srcs[2]),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pclk_o   (pclk_o),
        .irq      (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        srcs[idx] = 1'b1;
        @(negedge clk);
        srcs[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd2, v);  check("R1 enable state", v, 0);
        rd(4'd3, v);  check("R1 ready flags", v, 0);
        rd(4'd6, v);  check("R1 mask bits", v, 0);
        rd(4'd8, v);  check("R1 cfg0", v, 0);
        rd(4'd10, v); check("R1 cfg2", v, 0);
        check("R1 outputs", {29'd0, pclk_o}, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_cfg_fields;
        logic [31:0] v;
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, v);  check("R3 only field bits kept", v, 32'h1F);
        wr(4'd8, 32'h15);
        rd(4'd8, v);  check("R3 cfg0 main/32", v, 32'h15);
    endtask

    task automatic t_div32;
        logic [31:0] v;
        wr(4'd0, 32'h1);
        rd(4'd2, v); check("R2 ch0 enabled", v, 32'h1);
        for (int k = 0; k < 4; k++) begin
            pulse(0);
            pulse(2);
        end
        check("R4 unselected sources ignored", {31'd0, pclk_o[0]}, 0);
        for (int k = 0; k < 15; k++) pulse(1);
        check("R5 low before 16th edge", {31'd0, pclk_o[0]}, 0);
        rd(4'd3, v); check("R7 not ready before high", v, 0);
        pulse(1);
        check("R5 high at 16th edge", {31'd0, pclk_o[0]}, 1);
        rd(4'd3, v); check("R7 ready after first high", v, 32'h1);
        for (int k = 0; k < 16; k++) pulse(1);
        check("R5 low after 32 edges", {31'd0, pclk_o[0]}, 0);
        rd(4'd3, v); check("R7 ready held", v, 32'h1);
    endtask

    task automatic t_locked_cfg;
        logic [31:0] v;
        wr(4'd8, 32'h0A);
        rd(4'd8, v); check("R8 write while on ignored", v, 32'h15);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        for (int k = 0; k < 16; k++) pulse(1);
        check("R9 pre-disable output high", {31'd0, pclk_o[0]}, 1);
        wr(4'd1, 32'h1);
        check("R9 output low after disable", {31'd0, pclk_o[0]}, 0);
        rd(4'd3, v); check("R9 ready cleared", v, 0);
        rd(4'd2, v); check("R2 ch0 disabled", v, 0);
    endtask

    task automatic t_div2;
        logic [31:0] v;
        wr(4'd8, 32'h06);
        rd(4'd8, v); check("R3 cfg0 pll/2", v, 32'h06);
        wr(4'd0, 32'h1);
        pulse(2);
        check("R5 /2 high after 1st edge", {31'd0, pclk_o[0]}, 1);
        pulse(2);
        check("R5 /2 low after 2nd edge", {31'd0, pclk_o[0]}, 0);
        pulse(2);
        check("R5 /2 high after 3rd edge", {31'd0, pclk_o[0]}, 1);
        wr(4'd1, 32'h1);
    endtask

    task automatic t_div1;
        logic [31:0] v;
        wr(4'd9, 32'h02);
        wr(4'd0, 32'h2);
        @(negedge clk);
        srcs[2] = 1'b1;
        #1 check("R6 no same-cycle follow", {31'd0, pclk_o[1]}, 0);
        @(negedge clk);
        check("R6 follows high", {31'd0, pclk_o[1]}, 1);
        rd(4'd3, v); check("R7 ch1 ready", v, 32'h2);
        srcs[2] = 1'b0;
        @(negedge clk);
        check("R6 follows low", {31'd0, pclk_o[1]}, 0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        check("R10 irq low unmasked", {31'd0, irq}, 0);
        wr(4'd4, 32'h1);
        check("R10 mask on not-ready ch0", {31'd0, irq}, 0);
        wr(4'd4, 32'h2);
        rd(4'd6, v); check("R10 mask status", v, 32'h3);
        check("R10 irq high", {31'd0, irq}, 1);
        wr(4'd5, 32'h2);
        check("R10 irq low after clear", {31'd0, irq}, 0);
        wr(4'd5, 32'h1);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        wr(4'd10, 32'h00);
        wr(4'd0, 32'h4);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd1; wdata = 32'h4; srcs[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 collision output low", {31'd0, pclk_o[2]}, 0);
        rd(4'd3, v); check("R9 collision ready clear", v & 32'h4, 0);
        rd(4'd2, v); check("R9 collision disabled", v & 32'h4, 0);
        wr(4'd0, 32'h4);
        @(negedge clk);
        check("R6 control output high", {31'd0, pclk_o[2]}, 1);
        rd(4'd3, v); check("R7 control ready", v & 32'h4, 32'h4);
        srcs[0] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_fields();
        t_div32();
        t_locked_cfg();
        t_disable();
        t_div2();
        t_div1();
        t_irq();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule